// File: doc/BRIEF.md
# Rate-Corrected Precision Time Counter

This block keeps a 64-bit time-of-day count in 8 ns ticks for a packet timestamping path that runs on a nominal 125 MHz clock. Each cycle, a 31-bit fractional accumulator adds a software-set 32-bit rate word. The corrected count then moves forward by 0, 1 or 2 ticks, so a servo can trim the frequency by several percent in either direction. A second 64-bit counter runs freely beside it and advances by exactly one every cycle, whatever the rate word says.

Software reaches the block through a plain 32-bit register bus with address, write enable, read strobe, write data and combinational read data. A control word must carry a commit flag before it changes anything. Its other fields pick the meaning of a time write (absolute load or signed offset), pick which counter feeds the timestamp capture, and request a clear of the corrected count. A one-cycle event strobe copies the chosen counter into a capture register and raises a flag that a read of the capture clears. Both 64-bit counters read coherently as two 32-bit halves. A 64-bit time write is staged: the low half is held, and the write takes effect when the high half arrives.

Top module: `ptp_hw_clock`

## Requirements
- R1: After synchronous reset the corrected count and the free count are both 0 and the capture holds 0. The rate register (address 3) reads 0x80000000. The control register (address 0) reads 0x00000002, meaning capture from the corrected count with offset mode off. The capture flag (address 8, bit 0) reads 0.
- R2: The free count advances by exactly one on every clock edge out of reset, whatever the rate and whatever bus traffic occurs. Its low half is at address 4 and its high half at address 5.
- R3: The rate register is read/write at address 3. After a clear of the corrected count, that count equals floor(n·R / 2^31) n edges later for a rate word R held constant. R = 0x80000000 gives one tick per edge.
- R4: Reading a low half (address 1 for the corrected count, address 4 for the free count) with the read strobe copies the matching high half into a shadow. The next read of the high half (address 2 or 5) returns that shadow, so the pair forms the value at the moment of the low read.
- R5: A write to address 1 only stages 32 bits. When offset mode is off, a write to address 2 loads {written word, staged word} into the corrected count at that edge, and counting continues from the loaded value.
- R6: When offset mode is on, a write to address 2 adds {written word, staged word} as a two's complement tick offset. No tick of that cycle's advance is lost.
- R7: A write to the control register acts only if bit 31 is 1. Bit 0 sets offset mode, bit 1 selects the corrected count as the capture source (0 selects the free count), and bit 2 requests a clear. A write with bit 31 at 0 changes nothing.
- R8: A committed clear request sets control bit 2 for exactly one cycle. On the following edge the corrected count and the fractional accumulator both become 0.
- R9: An event strobe copies the selected counter's value in the strobe's cycle into the capture register (low half at address 6, high half at address 7). The capture holds that value until the next strobe.
- R10: A strobe sets the capture flag. A read strobe on address 7 clears it. When both occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timestamping clock, one tick period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_re | input | 1 | Read strobe, drives read side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| evt_stb | input | 1 | One-cycle timestamp capture request |
| tod_now | output | 64 | Live corrected count for downstream stampers |

## Verification
The bench uses the default widths: a 64-bit count, a 32-bit rate word with a 31-bit fraction, and a 4-bit address. With these sizes, every interesting rate is reachable within a few dozen cycles. This includes zero, the ±3.2 % limits, one LSB above nominal, 1.5× and all-ones, and each is checked against floor(n·R/2^31) at two different elapsed times after a clear. Loads close to 2^32 and 2^64 bring the low-word carry during a split read, and the 64-bit wrap, within a handful of cycles. Signed offsets are applied in both directions, and the same-cycle event and acknowledge collision is driven directly.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

    parameter int BUS_W  = 32;
    parameter int TIME_W = 2 * BUS_W;
    parameter int RATE_W = 32;
    parameter int ADDR_W = 4;

    localparam int FRAC_W = RATE_W - 1;
    localparam int STEP_W = RATE_W - FRAC_W + 1;

    localparam logic [RATE_W-1:0] RATE_NOMINAL = RATE_W'(1) << FRAC_W;

    // control word field positions
    localparam int CB_COMMIT = 31;
    localparam int CB_CLEAR  = 2;
    localparam int CB_TSCORR = 1;
    localparam int CB_ADD    = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_TOD_LO   = 4'd1,
        A_TOD_HI   = 4'd2,
        A_RATE     = 4'd3,
        A_FREE_LO  = 4'd4,
        A_FREE_HI  = 4'd5,
        A_STAMP_LO = 4'd6,
        A_STAMP_HI = 4'd7,
        A_STATUS   = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic ts_corr;
        logic add_mode;
    } clk_cfg_t;

    typedef struct packed {
        logic              load;
        logic              add;
        logic [TIME_W-1:0] value;
    } tod_wr_t;

    function automatic logic [TIME_W-1:0] join_words(input logic [BUS_W-1:0] hi,
                                                     input logic [BUS_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/ptpc_rate_acc.sv
module ptpc_rate_acc
    import ptpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic [STEP_W-1:0] step
);

    logic [FRAC_W-1:0] acc;
    logic [RATE_W:0]   sum;

    assign sum  = (RATE_W+1)'(acc) + (RATE_W+1)'(rate);
    assign step = sum[RATE_W:FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else begin
            acc <= sum[FRAC_W-1:0];
        end
    end

    // nominal rate leaves the fraction untouched
    p_nominal_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rate == RATE_NOMINAL && !clear) |=> acc == $past(acc));

    // a clear empties the fraction
    p_clear_frac_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc == '0);

endmodule

// File: rtl/ptpc_tod.sv
module ptpc_tod
    import ptpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [STEP_W-1:0] step,
    input  tod_wr_t           wr,
    output logic [TIME_W-1:0] tod
);

    logic [TIME_W-1:0] step_x;
    logic [TIME_W-1:0] advanced;

    assign step_x   = TIME_W'(step);
    assign advanced = tod + step_x;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tod <= '0;
        end else if (wr.load) begin
            tod <= wr.value;
        end else if (wr.add) begin
            tod <= advanced + wr.value;
        end else begin
            tod <= advanced;
        end
    end

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (!clear && !wr.load && !wr.add) |=> tod == $past(tod) + TIME_W'($past(step)));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear && wr.load) |=> tod == $past(wr.value));

    p_offset_r6: assert property (@(posedge clk) disable iff (rst)
        (!clear && !wr.load && wr.add) |=>
            tod == $past(tod) + $past(wr.value) + TIME_W'($past(step)));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> tod == '0);

endmodule

// File: rtl/ptpc_stamp.sv
module ptpc_stamp
    import ptpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              sel_corr,
    input  logic [TIME_W-1:0] tod,
    input  logic [TIME_W-1:0] free,
    input  logic              ack,
    output logic [TIME_W-1:0] stamp,
    output logic              valid
);

    logic [TIME_W-1:0] src;

    assign src = sel_corr ? tod : free;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp <= '0;
            valid <= 1'b0;
        end else begin
            if (evt) begin
                stamp <= src;
            end
            if (evt) begin
                valid <= 1'b1;
            end else if (ack) begin
                valid <= 1'b0;
            end
        end
    end

    p_stamp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(stamp));

    p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
        evt |=> valid);

    p_flag_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !evt) |=> !valid);

endmodule

// File: rtl/ptpc_regbus.sv
module ptpc_regbus
    import ptpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [TIME_W-1:0] tod,
    input  logic [TIME_W-1:0] free,
    input  logic [TIME_W-1:0] stamp,
    input  logic              stamp_valid,
    output logic [RATE_W-1:0] rate,
    output clk_cfg_t          cfg,
    output logic              clear,
    output tod_wr_t           tod_wr,
    output logic              stamp_ack
);

    logic             ctrl_hit;
    logic             commit;
    logic             hi_write;
    logic [BUS_W-1:0] stage_lo;
    logic [BUS_W-1:0] tod_shadow;
    logic [BUS_W-1:0] free_shadow;

    assign ctrl_hit  = we && (addr == A_CTRL);
    assign commit    = ctrl_hit && wdata[CB_COMMIT];
    assign hi_write  = we && (addr == A_TOD_HI);
    assign stamp_ack = re && (addr == A_STAMP_HI);

    always_comb begin
        tod_wr.value = join_words(wdata, stage_lo);
        tod_wr.load  = hi_write && !cfg.add_mode;
        tod_wr.add   = hi_write &&  cfg.add_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate        <= RATE_NOMINAL;
            cfg         <= '{ts_corr: 1'b1, add_mode: 1'b0};
            clear       <= 1'b0;
            stage_lo    <= '0;
            tod_shadow  <= '0;
            free_shadow <= '0;
        end else begin
            clear <= commit && wdata[CB_CLEAR];
            if (commit) begin
                cfg <= '{ts_corr: wdata[CB_TSCORR], add_mode: wdata[CB_ADD]};
            end
            if (we && (addr == A_RATE)) begin
                rate <= wdata[RATE_W-1:0];
            end
            if (we && (addr == A_TOD_LO)) begin
                stage_lo <= wdata;
            end
            if (re && (addr == A_TOD_LO)) begin
                tod_shadow <= tod[TIME_W-1:BUS_W];
            end
            if (re && (addr == A_FREE_LO)) begin
                free_shadow <= free[TIME_W-1:BUS_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CB_ADD]    = cfg.add_mode;
                rdata[CB_TSCORR] = cfg.ts_corr;
                rdata[CB_CLEAR]  = clear;
            end
            A_TOD_LO:   rdata = tod[BUS_W-1:0];
            A_TOD_HI:   rdata = tod_shadow;
            A_RATE:     rdata = BUS_W'(rate);
            A_FREE_LO:  rdata = free[BUS_W-1:0];
            A_FREE_HI:  rdata = free_shadow;
            A_STAMP_LO: rdata = stamp[BUS_W-1:0];
            A_STAMP_HI: rdata = stamp[TIME_W-1:BUS_W];
            A_STATUS:   rdata[0] = stamp_valid;
            default:    rdata = '0;
        endcase
    end

    p_ctrl_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && !wdata[CB_COMMIT]) |=> ($stable(cfg) && !clear));

    p_clear_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (clear && !commit) |=> !clear);

    p_shadow_r4: assert property (@(posedge clk) disable iff (rst)
        (re && addr == A_TOD_LO) |=> tod_shadow == $past(tod[TIME_W-1:BUS_W]));

endmodule

// File: rtl/ptp_hw_clock.sv
module ptp_hw_clock
    import ptpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              evt_stb,
    output logic [TIME_W-1:0] tod_now
);

    logic [TIME_W-1:0] free_q;
    logic [TIME_W-1:0] stamp;
    logic              stamp_valid;
    logic              stamp_ack;
    logic [RATE_W-1:0] rate;
    clk_cfg_t          cfg;
    logic              clear;
    tod_wr_t           tod_wr;
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '0;
        end else begin
            free_q <= free_q + TIME_W'(1);
        end
    end

    ptpc_regbus u_regbus (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .we          (bus_we),
        .re          (bus_re),
        .wdata       (bus_wdata),
        .rdata       (bus_rdata),
        .tod         (tod_now),
        .free        (free_q),
        .stamp       (stamp),
        .stamp_valid (stamp_valid),
        .rate        (rate),
        .cfg         (cfg),
        .clear       (clear),
        .tod_wr      (tod_wr),
        .stamp_ack   (stamp_ack)
    );

    ptpc_rate_acc u_rate (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .rate  (rate),
        .step  (step)
    );

    ptpc_tod u_tod (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .step  (step),
        .wr    (tod_wr),
        .tod   (tod_now)
    );

    ptpc_stamp u_stamp (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_stb),
        .sel_corr (cfg.ts_corr),
        .tod      (tod_now),
        .free     (free_q),
        .ack      (stamp_ack),
        .stamp    (stamp),
        .valid    (stamp_valid)
    );

    p_free_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> free_q == $past(free_q) + TIME_W'(1));

endmodule

// File: tb/ptp_hw_clock_bench.sv
module ptp_hw_clock_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'd0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        evt_stb = 1'b0;
    logic [63:0] tod_now;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    ptp_hw_clock u_ptp_hw_clock (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_stb   (evt_stb),
        .tod_now   (tod_now)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output int unsigned c);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata; c = cyc;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd64(input logic [3:0] lo_a, output logic [63:0] v, output int unsigned c);
        logic [31:0] lo;
        logic [31:0] hi;
        int unsigned c2;
        bus_read(lo_a, lo, c);
        bus_read(lo_a + 4'd1, hi, c2);
        v = {hi, lo};
    endtask

    // load an absolute time, returning the edge count at the load
    task automatic load_time(input logic [63:0] t, output int unsigned wc);
        bus_write(4'd1, t[31:0]);
        bus_write(4'd2, t[63:32]);
        wc = cyc;
    endtask

    function automatic logic [63:0] rate_ticks(input int unsigned n, input logic [31:0] r);
        return (64'(n) * 64'(r)) >> 31;
    endfunction

    initial begin
        logic [31:0] w;
        logic [63:0] v;
        logic [63:0] t0;
        logic [63:0] d;
        int unsigned c;
        int unsigned wc;
        int unsigned cc;
        int unsigned ce;
        logic [31:0] rates [8];
        rates = '{32'h8000_0000, 32'h8418_9374, 32'h7BE7_6C8C, 32'h4000_0000,
                  32'h0000_0000, 32'hC000_0000, 32'hFFFF_FFFF, 32'h8000_0001};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset state
        bus_read(4'd0, w, c);  check("R1 ctrl", 64'(w), 64'h2);
        bus_read(4'd3, w, c);  check("R1 rate", 64'(w), 64'h8000_0000);
        bus_read(4'd8, w, c);  check("R1 flag", 64'(w), 64'h0);
        rd64(4'd6, v, c);      check("R1 stamp", v, 64'h0);
        rd64(4'd1, v, c);      check("R1 tod from zero", v, 64'(c));

        // R2: free count tracks edges since reset
        for (int i = 0; i < 3; i++) begin
            repeat (i * 5 + 1) @(negedge clk);
            rd64(4'd4, v, c);
            check("R2 free", v, 64'(c));
        end

        // R5 and R4: absolute loads, including word carry and 64-bit wrap
        begin
            logic [63:0] loads [4];
            loads = '{64'h0123_4567_89AB_CDEF, 64'h0000_0005_FFFF_FFFF,
                      64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_FFFF_FFFF};
            for (int i = 0; i < 4; i++) begin
                load_time(loads[i], wc);
                repeat (i) @(negedge clk);
                rd64(4'd1, v, c);
                check("R5 load", v, loads[i] + 64'(c - wc));
                // R4: low half read just before a carry, high half after it
                check("R4 coherent", v, 64'(tod_now - 64'(cyc - c)));
            end
        end

        // R6: signed offsets in offset mode
        load_time(64'h0000_0010_0000_0000, wc);
        t0 = 64'h0000_0010_0000_0000;
        bus_write(4'd0, 32'h8000_0003);
        d = -64'sd1000;
        bus_write(4'd1, d[31:0]);
        bus_write(4'd2, d[63:32]);
        rd64(4'd1, v, c);
        check("R6 negative offset", v, t0 + 64'(c - wc) + d);
        bus_write(4'd1, 32'h0000_0000);
        bus_write(4'd2, 32'h0000_0001);
        d = d + 64'h1_0000_0000;
        rd64(4'd1, v, c);
        check("R6 positive offset", v, t0 + 64'(c - wc) + d);

        // R7: uncommitted control writes change nothing
        bus_write(4'd0, 32'h0000_0004);
        bus_read(4'd0, w, c);
        check("R7 ctrl kept", 64'(w), 64'h3);
        rd64(4'd1, v, c);
        check("R7 no clear", v, t0 + 64'(c - wc) + d);
        bus_write(4'd0, 32'h0000_0000);
        bus_read(4'd0, w, c);
        check("R7 mode kept", 64'(w), 64'h3);

        // R3 and R8: rate sweep, each after a committed clear
        foreach (rates[i]) begin
            bus_write(4'd3, rates[i]);
            bus_read(4'd3, w, c);
            check("R3 rate readback", 64'(w), 64'(rates[i]));
            bus_write(4'd0, 32'h8000_0006);
            cc = cyc + 1;
            repeat (3 + i) @(negedge clk);
            rd64(4'd1, v, c);
            check("R3 R8 rate early", v, rate_ticks(c - cc, rates[i]));
            repeat (17 + 7 * i) @(negedge clk);
            rd64(4'd1, v, c);
            check("R3 rate late", v, rate_ticks(c - cc, rates[i]));
            rd64(4'd4, v, c);
            check("R2 free under rate", v, 64'(c));
        end
        bus_read(4'd0, w, c);
        check("R8 clear bit dropped", 64'(w), 64'h2);

        // R9 and R10: capture from the corrected count
        bus_write(4'd3, 32'h8000_0000);
        load_time(64'h0000_0ABC_0000_1000, wc);
        repeat (4) @(negedge clk);
        @(negedge clk); evt_stb = 1'b1; ce = cyc;
        @(negedge clk); evt_stb = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(4'd8, w, c);  check("R10 flag set", 64'(w), 64'h1);
        rd64(4'd6, v, c);
        check("R9 corrected capture", v, 64'h0000_0ABC_0000_1000 + 64'(ce - wc));
        bus_read(4'd8, w, c);  check("R10 flag cleared", 64'(w), 64'h0);

        // R9: capture from the free count
        bus_write(4'd0, 32'h8000_0000);
        @(negedge clk); evt_stb = 1'b1; ce = cyc;
        @(negedge clk); evt_stb = 1'b0;
        rd64(4'd6, v, c);
        check("R9 free capture", v, 64'(ce));
        repeat (5) @(negedge clk);
        rd64(4'd6, v, c);
        check("R9 capture held", v, 64'(ce));

        // R10: strobe and acknowledge in one cycle
        @(negedge clk);
        bus_addr = 4'd7; bus_re = 1'b1; evt_stb = 1'b1; ce = cyc;
        @(negedge clk);
        bus_re = 1'b0; evt_stb = 1'b0;
        bus_read(4'd8, w, c);
        check("R10 strobe wins", 64'(w), 64'h1);
        rd64(4'd6, v, c);
        check("R9 collision capture", v, 64'(ce));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule